// File: doc/BRIEF.md
# Dual-Mode Buffered PWM Channel

This block is a single pulse-width modulation channel built around an up/down counter. It produces either an edge-aligned waveform, where the counter wraps from the period value back to zero, or a center-aligned waveform, where the counter climbs to the period value and then descends back to zero. In both modes the output is high whenever the counter is at or above the active pulse-width value. The channel does no output pin combining, holds no interrupt flags and has no single-shot operation.

Software writes three values through one register write port: the counter itself, the period and the pulse width. The period and pulse width each have a working copy (shadow) that the compare logic actually uses. While the channel runs, the shadows take the written values only at the start of the next PWM cycle, so a waveform is never torn mid-cycle. While the channel is stopped, a write goes straight into the shadow. A one-clock strobe marks each cycle start, which is when new values may safely be written. Each count step comes either from every clock or from every 64th clock, according to a select pin. The mode select should be changed only while the channel is stopped.

Top module: `bpwm_channel`

## Requirements
- R1: After reset the counter, the direction (up), both software registers and both shadows are zero, so `pwm_out` is 1 and `cycle_start` is 0.
- R2: In edge-aligned mode (`center_mode`=0) the counter steps 0,1,…,P and wraps to 0 on the following step. The PWM period is P+1 count steps, where P is the period shadow.
- R3: In center-aligned mode (`center_mode`=1) the counter steps 0,1,…,P,P,P−1,…,1,0. The value is held for one extra step at each turnaround, so the period is 2·(P+1) count steps. With P=3 and width 3, the output over one period starting just after a cycle start is 0,0,0,1,1,0,0,0.
- R4: `pwm_out` is 1 exactly when the counter is ≥ the width shadow W. For 0<W≤P this gives P+1−W high steps per period in edge mode and 2·(P+1−W) in center mode.
- R5: W=0 keeps `pwm_out` constantly 1. W>P keeps it constantly 0, in both modes.
- R6: While `run`=1, writes to the period (`wr_sel`=2'b01) or width (`wr_sel`=2'b10) register leave the shadows unchanged until the next cycle start. At that point both shadows reload from the registers.
- R7: While `run`=0, a period or width write also copies into the shadow, and `pwm_out` reflects the new width one clock later.
- R8: With `slow_sel`=1 the counter takes one step per 64 clocks. With `slow_sel`=0 it takes one step per clock.
- R9: With `run`=0 and no write, the counter and `pwm_out` hold their values and `cycle_start` stays 0.
- R10: A counter write (`wr_sel`=2'b00) loads the counter on that edge, ahead of any count step, whether or not the channel runs. `pwm_out` shows the new comparison one clock later. `wr_sel`=2'b11 writes nothing.
- R11: `cycle_start` is high for exactly one clock per PWM period. That is the clock whose edge reloads the shadows: in edge mode the wrap from P, in center mode the upward turn at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Count enable; 0 freezes the channel |
| slow_sel | input | 1 | 1: one count step per 64 clocks; 0: every clock |
| center_mode | input | 1 | 1: center-aligned; 0: edge-aligned |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 00 counter, 01 period, 10 width, 11 none |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | 1 | Raw PWM output |
| cycle_start | output | 1 | One-clock strobe at each shadow reload |

## Verification
The bench builds the channel with its default 16-bit counter and divide-by-64 prescaler. It keeps the period values small, from 1 to 7, so whole PWM periods fit in short observation windows. Edge, center, zero-width and over-period widths, and running versus stopped writes are all checked by counting highs and strobes over windows whose length is a whole number of periods. With a period of 1 under the slow prescaler, each period lasts 128 clocks, so the divide-by-64 path is reached within a few hundred cycles.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'b00,
    SEL_PERIOD = 2'b01,
    SEL_WIDTH  = 2'b10,
    SEL_NONE   = 2'b11
  } bpwm_sel_e;

  localparam int unsigned NUM_BUF    = 2;
  localparam int unsigned IDX_PERIOD = 0;
  localparam int unsigned IDX_WIDTH  = 1;

  function automatic bpwm_sel_e buf_sel(input int unsigned idx);
    return (idx == IDX_PERIOD) ? SEL_PERIOD : SEL_WIDTH;
  endfunction

endpackage

// File: rtl/bpwm_tick.sv
module bpwm_tick #(
  parameter int unsigned DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_sel,
  output logic tick
);

  logic wrap;

  generate
    if (DIV_LOG2 == 0) begin : g_nodiv
      assign wrap = 1'b1;
    end else begin : g_div
      logic [DIV_LOG2-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
      end
      assign wrap = &pre_q;
    end
  endgenerate

  assign tick = slow_sel ? wrap : 1'b1;

endmodule

// File: rtl/bpwm_shadow_bank.sv
module bpwm_shadow_bank
  import bpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  bpwm_sel_e                        wr_sel,
  input  logic [CNT_W-1:0]                 wr_data,
  input  logic                             running,
  input  logic                             reload,
  output logic [NUM_BUF-1:0][CNT_W-1:0]    shadow_q
);

  generate
    for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
      logic [CNT_W-1:0] host_q;
      logic [CNT_W-1:0] sh_q;
      logic             hit;

      assign hit = wr_en && (wr_sel == buf_sel(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          host_q <= '0;
          sh_q   <= '0;
        end else begin
          if (hit) host_q <= wr_data;
          if (reload)
            sh_q <= host_q;
          else if (hit && !running)
            sh_q <= wr_data;
        end
      end

      assign shadow_q[g] = sh_q;
    end
  endgenerate

endmodule

// File: rtl/bpwm_updown.sv
module bpwm_updown #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             center,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_data,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt_q,
  output logic             down_q,
  output logic             cycle_end
);

  logic [CNT_W-1:0] cnt_d;
  logic             down_d;
  logic             at_top;
  logic             at_zero;
  logic             turn_top;
  logic             turn_bot;
  logic             wrap_edge;

  always_comb begin
    at_top    = (cnt_q == period);
    at_zero   = (cnt_q == '0);
    turn_top  = center && !down_q && at_top;
    turn_bot  = center &&  down_q && at_zero;
    wrap_edge = !center && at_top;
    cycle_end = step && !ld_en && (wrap_edge || turn_bot);

    cnt_d  = cnt_q;
    down_d = down_q;
    if (ld_en) begin
      cnt_d = ld_data;
    end else if (step) begin
      if (!center) begin
        down_d = 1'b0;
        cnt_d  = at_top ? '0 : cnt_q + 1'b1;
      end else if (turn_top) begin
        down_d = 1'b1;
      end else if (turn_bot) begin
        down_d = 1'b0;
      end else if (down_q) begin
        cnt_d = cnt_q - 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

endmodule

// File: rtl/bpwm_cmp.sv
module bpwm_cmp #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] width,
  output logic             level
);

  assign level = (cnt >= width);

endmodule

// File: rtl/bpwm_channel.sv
module bpwm_channel
  import bpwm_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DIV_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             slow_sel,
  input  logic             center_mode,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out,
  output logic             cycle_start
);

  bpwm_sel_e                       sel_e;
  logic                            tick;
  logic                            step;
  logic                            cnt_ld;
  logic [NUM_BUF-1:0][CNT_W-1:0]   shadows;
  logic [CNT_W-1:0]                per_sh;
  logic [CNT_W-1:0]                wid_sh;
  logic [CNT_W-1:0]                cnt_q;
  logic                            down_q;
  logic                            cycle_end;

  assign sel_e  = bpwm_sel_e'(wr_sel);
  assign step   = run && tick;
  assign cnt_ld = wr_en && (sel_e == SEL_COUNT);
  assign per_sh = shadows[IDX_PERIOD];
  assign wid_sh = shadows[IDX_WIDTH];

  bpwm_tick #(.DIV_LOG2(DIV_LOG2)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_sel (slow_sel),
    .tick     (tick)
  );

  bpwm_shadow_bank #(.CNT_W(CNT_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (sel_e),
    .wr_data  (wr_data),
    .running  (run),
    .reload   (cycle_end),
    .shadow_q (shadows)
  );

  bpwm_updown #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .center    (center_mode),
    .ld_en     (cnt_ld),
    .ld_data   (wr_data),
    .period    (per_sh),
    .cnt_q     (cnt_q),
    .down_q    (down_q),
    .cycle_end (cycle_end)
  );

  bpwm_cmp #(.CNT_W(CNT_W)) u_cmp (
    .cnt   (cnt_q),
    .width (wid_sh),
    .level (pwm_out)
  );

  assign cycle_start = cycle_end;

endmodule

// File: rtl/bpwm_checker.sv
module bpwm_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic             pwm_out,
  input logic             cycle_start,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] per_sh,
  input logic [CNT_W-1:0] wid_sh
);

  AST_STROBE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> run); // R11

  AST_FROZEN_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> $stable(pwm_out)); // R9

  AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> $stable(cnt_q)); // R9

  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cycle_start) |=> ($stable(per_sh) && $stable(wid_sh))); // R6

  AST_ZERO_WIDTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wid_sh == '0) |-> pwm_out); // R5

  AST_WIDE_WIDTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((wid_sh > per_sh) && (cnt_q <= per_sh)) |-> !pwm_out); // R5

  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_sel == 2'b00)) |=> (cnt_q == $past(wr_data))); // R10

endmodule

bind bpwm_channel bpwm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run         (run),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .pwm_out     (pwm_out),
  .cycle_start (cycle_start),
  .cnt_q       (cnt_q),
  .per_sh      (per_sh),
  .wid_sh      (wid_sh)
);

// File: tb/sim_bpwm_channel.sv
`timescale 1ns/1ps
module sim_bpwm_channel;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic          slow_sel = 1'b0;
  logic          center_mode = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'b11;
  logic [CW-1:0] wr_data = '0;
  logic          pwm_out;
  logic          cycle_start;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bpwm_channel #(.CNT_W(CW), .DIV_LOG2(6)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .slow_sel(slow_sel),
    .center_mode(center_mode), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pwm_out(pwm_out), .cycle_start(cycle_start)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int data);
    wr_en = 1'b1; wr_sel = sel; wr_data = CW'(data);
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'b11;
  endtask

  task automatic align(input string req);
    bit seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (cycle_start) seen = 1;
    end
    chk(seen, req, 0, 1);
  endtask

  task automatic measure(input int n, output int strobes, output int highs);
    strobes = 0; highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      strobes += int'(cycle_start);
      highs   += int'(pwm_out);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pwm_out == 1'b1, "R1 out after reset", int'(pwm_out), 1);
    chk(cycle_start == 1'b0, "R1 strobe after reset", int'(cycle_start), 0);
  endtask

  task automatic t_stopped_load();
    run = 1'b0;
    wr(2'b01, 4);
    wr(2'b10, 2);
    chk(pwm_out == 1'b0, "R7 width 2 loaded while stopped", int'(pwm_out), 0);
    wr(2'b10, 0);
    chk(pwm_out == 1'b1, "R7 width 0 loaded while stopped", int'(pwm_out), 1);
    wr(2'b10, 2);
    chk(pwm_out == 1'b0, "R7 width 2 reloaded", int'(pwm_out), 0);
  endtask

  task automatic t_cnt_write_stopped();
    wr(2'b00, 3);
    chk(pwm_out == 1'b1, "R10 counter 3 vs width 2", int'(pwm_out), 1);
    wr(2'b00, 1);
    chk(pwm_out == 1'b0, "R10 counter 1 vs width 2", int'(pwm_out), 0);
    wr(2'b11, 0);
    chk(pwm_out == 1'b0, "R10 select 11 writes nothing", int'(pwm_out), 0);
    wr(2'b00, 0);
  endtask

  task automatic t_edge();
    int s, h;
    run = 1'b1;
    align("R11 edge strobe seen");
    measure(15, s, h);
    chk(s == 3, "R2 edge P=4 strobes in 15", s, 3);
    chk(h == 9, "R4 edge P=4 W=2 highs in 15", h, 9);
  endtask

  task automatic t_running_buffered();
    int s, h;
    align("R6 align");
    @(negedge clk);
    wr(2'b10, 4);
    chk(pwm_out == 1'b0, "R6 count 1 under old width", int'(pwm_out), 0);
    @(negedge clk);
    chk(pwm_out == 1'b1, "R6 old width still active", int'(pwm_out), 1);
    wr(2'b01, 7);
    align("R6 align after writes");
    measure(16, s, h);
    chk(s == 2, "R6 new period 7 strobes in 16", s, 2);
    chk(h == 8, "R6 new width 4 highs in 16", h, 8);
  endtask

  task automatic t_freeze();
    int s, h;
    logic v;
    run = 1'b0;
    @(negedge clk);
    v = pwm_out;
    measure(40, s, h);
    chk(s == 0, "R9 no strobe while stopped", s, 0);
    chk(h == (v ? 40 : 0), "R9 output held while stopped", h, v ? 40 : 0);
  endtask

  task automatic t_cnt_write_running();
    run = 1'b1;
    wr(2'b00, 5);
    chk(pwm_out == 1'b1, "R10 running load 5 vs width 4", int'(pwm_out), 1);
    wr(2'b00, 2);
    chk(pwm_out == 1'b0, "R10 running load 2 vs width 4", int'(pwm_out), 0);
  endtask

  task automatic t_edge_extremes();
    int s, h;
    run = 1'b0;
    wr(2'b10, 0);
    run = 1'b1;
    measure(16, s, h);
    chk(h == 16, "R5 edge width 0 always high", h, 16);
    wr(2'b10, 9);
    align("R5 align");
    measure(16, s, h);
    chk(h == 0, "R5 edge width above period always low", h, 0);
    chk(s == 2, "R11 edge P=7 strobes in 16", s, 2);
  endtask

  task automatic t_center();
    int s, h;
    logic [7:0] shape;
    run = 1'b0;
    center_mode = 1'b1;
    wr(2'b00, 0);
    wr(2'b01, 3);
    wr(2'b10, 1);
    run = 1'b1;
    align("R3 align");
    measure(16, s, h);
    chk(s == 2, "R3 center P=3 strobes in 16", s, 2);
    chk(h == 12, "R4 center W=1 highs in 16", h, 12);
    wr(2'b10, 3);
    align("R3 align W=3");
    shape = '0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      shape[7-i] = pwm_out;
    end
    chk(shape == 8'b0001_1000, "R3 center turnaround shape", int'(shape), 8'h18);
    wr(2'b10, 0);
    align("R5 align center");
    measure(16, s, h);
    chk(h == 16, "R5 center width 0 always high", h, 16);
    wr(2'b10, 5);
    align("R5 align center wide");
    measure(16, s, h);
    chk(h == 0, "R5 center width above period always low", h, 0);
  endtask

  task automatic t_slow();
    int s, h;
    run = 1'b0;
    center_mode = 1'b0;
    wr(2'b00, 0);
    wr(2'b01, 1);
    wr(2'b10, 1);
    slow_sel = 1'b1;
    run = 1'b1;
    align("R8 slow align");
    measure(256, s, h);
    chk(s == 2, "R8 R11 slow P=1 strobes in 256", s, 2);
    chk(h == 128, "R8 slow P=1 W=1 highs in 256", h, 128);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stopped_load();
    t_cnt_write_stopped();
    t_edge();
    t_running_buffered();
    t_freeze();
    t_cnt_write_running();
    t_edge_extremes();
    t_center();
    t_slow();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule